// File: doc/BRIEF.md
# Filtered Reset Sequencer

This block turns a noisy, asynchronous, active-low reset pin into a clean internal reset for a microcontroller core. The pin first passes through a synchronizer. A filter counter then requires the pin to be seen low on several consecutive clock edges, so short glitches are ignored. Once a reset is confirmed, the internal reset is latched. It is held for a fixed minimum number of clocks, or for as long as the pin stays low if that is longer.

While the internal reset is active, the block drives the external bus strobes into their reset pattern. The data strobe is held low. The address strobe flips on every clock, so that a single cycle shows it pulsing. When the internal reset drops, a one-cycle load pulse tells the core to take the start address from a constant vector output. That vector defaults to 0x000C.

Top module: `rst_sequencer`

## Requirements
- R1: While `rst` is high, and in the first cycle after it falls, `core_rst` is 0, `ds_n` is 1, `as_n` is 1 and `pc_load` is 0.
- R2: If `ext_rst_n` is sampled low on fewer than FILT_CLKS (default 4) consecutive rising edges, `core_rst` never rises.
- R3: If `ext_rst_n` is sampled low on FILT_CLKS consecutive rising edges, `core_rst` is 1 after the sixth rising edge, counting the first edge that samples it low. It is still 0 after the fifth.
- R4: If `ext_rst_n` has been high for at least two edges by the end of the hold, `core_rst` stays 1 for exactly HOLD_CLKS (default 18) cycles.
- R5: If `ext_rst_n` is still low when the minimum hold ends, `core_rst` stays 1 until the third rising edge that follows, counting the first edge that samples the pin high again, and falls at that edge.
- R6: `ds_n` is 0 in exactly those cycles in which `core_rst` is 1.
- R7: `as_n` is 0 in the first cycle of `core_rst`, inverts on every further cycle of `core_rst`, and is 1 whenever `core_rst` is 0.
- R8: `pc_load` is 1 for exactly one cycle, the first cycle after `core_rst` falls. `pc_vec` always reads START_ADDR (default 0x000C, 16 bits).
- R9: A single high sample between low runs restarts the filter count, so two runs that are each shorter than FILT_CLKS do not add up to a reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high power-on clear |
| ext_rst_n | input | 1 | Asynchronous external reset pin, active low |
| core_rst | output | 1 | Filtered and stretched internal reset, active high |
| ds_n | output | 1 | Data strobe, active low |
| as_n | output | 1 | Address strobe, active low |
| pc_load | output | 1 | One-cycle pulse that loads the start address |
| pc_vec | output | PC_W | Program counter start address |

## Verification
The bench applies low runs of three and four clocks, which separate a rejected glitch from an accepted reset and pin down the latch latency. It splits two short low runs with a single high sample, which shows whether the filter restarts or keeps counting. A short low that is released before the hold ends exposes the fixed minimum. A long low that outlasts the hold exposes the release that follows the pin. Random low and high runs of 1 to 25 clocks then exercise re-triggers just after release. In every cycle they are compared against a cycle model of the requirements, which covers the strobe pattern and the load pulse.

// File: rtl/rst_seq_pkg.sv
package rst_seq_pkg;
  typedef enum logic {
    ST_RUN  = 1'b0,
    ST_HELD = 1'b1
  } hold_state_e;
endpackage

// File: rtl/rst_seq_sync.sv
module rst_seq_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic d_in,
  output logic q_out
);
  logic [STAGES-1:0] chain;

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) chain[0] <= 1'b1;
          else     chain[0] <= d_in;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) chain[i] <= 1'b1;
          else     chain[i] <= chain[i-1];
        end
      end
    end
  endgenerate

  assign q_out = chain[STAGES-1];
endmodule

// File: rtl/rst_seq_filter.sv
module rst_seq_filter #(
  parameter int FILT_CLKS = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic pin_low,
  input  logic busy,
  output logic confirm
);
  localparam int CW = $clog2(FILT_CLKS + 1);
  localparam logic [CW-1:0] LAST = CW'(FILT_CLKS - 1);

  logic [CW-1:0] low_cnt;

  assign confirm = !busy && pin_low && (low_cnt == LAST);

  always_ff @(posedge clk) begin
    if (rst || busy || !pin_low) low_cnt <= '0;
    else if (low_cnt != LAST)    low_cnt <= low_cnt + 1'b1;
  end
endmodule

// File: rtl/rst_seq_hold.sv
module rst_seq_hold
  import rst_seq_pkg::*;
#(
  parameter int HOLD_CLKS = 18
) (
  input  logic clk,
  input  logic rst,
  input  logic confirm,
  input  logic pin_low,
  output logic core_rst,
  output logic rst_nxt,
  output logic pc_load
);
  localparam int HW = $clog2(HOLD_CLKS + 1);
  localparam logic [HW-1:0] HLAST = HW'(HOLD_CLKS - 1);

  hold_state_e state;
  logic [HW-1:0] hcnt;
  logic release_now;

  assign release_now = (state == ST_HELD) && (hcnt >= HLAST) && !pin_low;
  assign rst_nxt     = (state == ST_HELD) ? !release_now : confirm;
  assign core_rst    = (state == ST_HELD);

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= ST_RUN;
      hcnt    <= '0;
      pc_load <= 1'b0;
    end else begin
      pc_load <= release_now;
      state   <= rst_nxt ? ST_HELD : ST_RUN;
      if (state != ST_HELD)  hcnt <= '0;
      else if (hcnt < HLAST) hcnt <= hcnt + 1'b1;
    end
  end
endmodule

// File: rtl/rst_seq_strobe.sv
module rst_seq_strobe (
  input  logic clk,
  input  logic rst,
  input  logic rst_nxt,
  input  logic core_rst,
  output logic ds_n,
  output logic as_n
);
  always_ff @(posedge clk) begin
    if (rst) begin
      ds_n <= 1'b1;
      as_n <= 1'b1;
    end else begin
      ds_n <= !rst_nxt;
      if (!rst_nxt)      as_n <= 1'b1;
      else if (core_rst) as_n <= !as_n;
      else               as_n <= 1'b0;
    end
  end
endmodule

// File: rtl/rst_sequencer.sv
module rst_sequencer #(
  parameter int          SYNC_STAGES = 2,
  parameter int          FILT_CLKS   = 4,
  parameter int          HOLD_CLKS   = 18,
  parameter int          PC_W        = 16,
  parameter logic [31:0] START_ADDR  = 32'h0000_000C
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            ext_rst_n,
  output logic            core_rst,
  output logic            ds_n,
  output logic            as_n,
  output logic            pc_load,
  output logic [PC_W-1:0] pc_vec
);
  logic pin_q;
  logic pin_low;
  logic confirm;
  logic rst_nxt;

  rst_seq_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .d_in(ext_rst_n), .q_out(pin_q)
  );

  assign pin_low = !pin_q;

  rst_seq_filter #(.FILT_CLKS(FILT_CLKS)) u_filt (
    .clk(clk), .rst(rst), .pin_low(pin_low), .busy(core_rst), .confirm(confirm)
  );

  rst_seq_hold #(.HOLD_CLKS(HOLD_CLKS)) u_hold (
    .clk(clk), .rst(rst), .confirm(confirm), .pin_low(pin_low),
    .core_rst(core_rst), .rst_nxt(rst_nxt), .pc_load(pc_load)
  );

  rst_seq_strobe u_strb (
    .clk(clk), .rst(rst), .rst_nxt(rst_nxt), .core_rst(core_rst),
    .ds_n(ds_n), .as_n(as_n)
  );

  assign pc_vec = START_ADDR[PC_W-1:0];
endmodule

// File: rtl/rst_sequencer_chk.sv
module rst_sequencer_chk #(
  parameter int HOLD_CLKS = 18
) (
  input logic clk,
  input logic rst,
  input logic core_rst,
  input logic ds_n,
  input logic as_n,
  input logic pc_load
);
  localparam int RW = $clog2(HOLD_CLKS + 2) + 1;
  logic [RW-1:0] run_cnt;

  always_ff @(posedge clk) begin
    if (rst)           run_cnt <= '0;
    else if (core_rst) run_cnt <= (run_cnt == {RW{1'b1}}) ? run_cnt : run_cnt + 1'b1;
    else               run_cnt <= '0;
  end

  // R6
  ds_follows_rst_chk: assert property (@(posedge clk) disable iff (rst)
    ds_n == !core_rst);

  // R7
  as_starts_low_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(core_rst) |-> !as_n);

  // R7
  as_toggles_chk: assert property (@(posedge clk) disable iff (rst)
    core_rst |=> (!core_rst || as_n != $past(as_n)));

  // R7
  as_idle_chk: assert property (@(posedge clk) disable iff (rst)
    !core_rst |-> as_n);

  // R8
  load_on_release_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(core_rst) |-> pc_load);

  // R8
  load_single_chk: assert property (@(posedge clk) disable iff (rst)
    pc_load |=> !pc_load);

  // R4
  min_hold_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(core_rst) |-> (run_cnt >= RW'(HOLD_CLKS)));
endmodule

bind rst_sequencer rst_sequencer_chk #(.HOLD_CLKS(HOLD_CLKS)) u_chk (
  .clk(clk), .rst(rst), .core_rst(core_rst), .ds_n(ds_n), .as_n(as_n), .pc_load(pc_load)
);

// File: tb/sim_rst_sequencer.sv
module sim_rst_sequencer;
  localparam int FILT = 4;
  localparam int HOLD = 18;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic ext_rst_n = 1'b1;
  logic core_rst, ds_n, as_n, pc_load;
  logic [15:0] pc_vec;

  int n_chk = 0;
  int n_err = 0;
  bit model_on = 1'b0;

  always #10 clk = ~clk;

  rst_sequencer u0 (
    .clk(clk), .rst(rst), .ext_rst_n(ext_rst_n), .core_rst(core_rst),
    .ds_n(ds_n), .as_n(as_n), .pc_load(pc_load), .pc_vec(pc_vec)
  );

  task automatic check(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  // cycle model of the requirements
  bit m_s1, m_s2, m_rst, m_as, m_load;
  int m_cnt, m_h;
  always @(posedge clk) begin
    bit low, conf, rel, nrst;
    if (rst) begin
      m_s1 = 1; m_s2 = 1; m_rst = 0; m_as = 1; m_load = 0; m_cnt = 0; m_h = 0;
    end else begin
      low  = !m_s2;
      conf = !m_rst && low && (m_cnt + 1 >= FILT);
      rel  = m_rst && (m_h + 1 >= HOLD) && !low;
      nrst = m_rst ? !rel : conf;
      m_as = nrst ? (m_rst ? !m_as : 1'b0) : 1'b1;
      m_cnt = (m_rst || !low) ? 0 : ((m_cnt + 1 >= FILT) ? m_cnt : m_cnt + 1);
      m_h   = !m_rst ? 0 : ((m_h + 1 < HOLD) ? m_h + 1 : m_h);
      m_load = rel;
      m_rst  = nrst;
      m_s2   = m_s1;
      m_s1   = ext_rst_n;
    end
  end

  always @(negedge clk) begin
    if (model_on && !rst) begin
      check("R2 R3 R4 R5 core_rst", core_rst, m_rst);
      check("R6 ds_n", ds_n, !m_rst);
      check("R7 as_n", as_n, m_as);
      check("R8 pc_load", pc_load, m_load);
      check("R8 pc_vec", pc_vec, 16'h000C);
    end
  end

  task automatic low_for(input int n);
    ext_rst_n = 1'b0;
    repeat (n) @(negedge clk);
    ext_rst_n = 1'b1;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    #(200000 * 20);
    n_chk++; n_err++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    int hi_cnt;
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    // R1 reset state during and after rst
    check("R1 core_rst", core_rst, 0);
    check("R1 ds_n", ds_n, 1);
    check("R1 as_n", as_n, 1);
    rst = 1'b0;
    @(negedge clk);
    check("R1 core_rst", core_rst, 0);
    check("R1 pc_load", pc_load, 0);
    model_on = 1'b1;
    idle(3);

    // R2 glitch of three clocks
    low_for(3);
    hi_cnt = 0;
    for (int i = 0; i < 12; i++) begin @(negedge clk); hi_cnt += core_rst; end
    check("R2 no reset on 3-clock low", hi_cnt, 0);

    // R9 two short runs split by one high sample
    low_for(3);
    @(negedge clk);
    low_for(3);
    hi_cnt = 0;
    for (int i = 0; i < 12; i++) begin @(negedge clk); hi_cnt += core_rst; end
    check("R9 runs do not accumulate", hi_cnt, 0);

    // R3 latency and R4 exact minimum hold
    ext_rst_n = 1'b0;
    idle(5);
    check("R3 not yet after 5 edges", core_rst, 0);
    idle(1);
    check("R3 asserted after 6 edges", core_rst, 1);
    check("R7 first as_n low", as_n, 0);
    ext_rst_n = 1'b1;
    hi_cnt = 1;
    while (core_rst && hi_cnt < 100) begin @(negedge clk); hi_cnt += core_rst; end
    check("R4 hold length", hi_cnt, HOLD);
    check("R8 load pulse at release", pc_load, 1);
    @(negedge clk);
    check("R8 load is single", pc_load, 0);
    idle(4);

    // R5 long low outlasting the hold
    ext_rst_n = 1'b0;
    idle(40);
    check("R5 still held while low", core_rst, 1);
    ext_rst_n = 1'b1;
    idle(2);
    check("R5 held two edges after rise", core_rst, 1);
    idle(1);
    check("R5 released on third edge", core_rst, 0);
    check("R8 load after long low", pc_load, 1);
    idle(4);

    // random runs checked against the model
    for (int k = 0; k < 400; k++) begin
      ext_rst_n = $urandom_range(0, 1);
      idle($urandom_range(1, 25));
    end
    ext_rst_n = 1'b1;
    idle(40);
    check("R1 idle after random", core_rst, 0);

    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule